// File: doc/BRIEF.md
# Block Cipher Context and Interrupt Controller

This block is the host-side register file and control sequencer for a 64-bit block cipher accelerator. A host on a simple 32-bit memory-mapped bus loads up to three 64-bit keys, a 64-bit initialization vector and a control word. It then writes a byte count, and that write starts a context. The block collects each 64-bit data block from two 32-bit writes and hands it to an external cipher core over a start/done interface. It captures the core's result in an output window and counts the remaining length down until the context is finished.

Ready flags in the control word pace the host. Three sticky interrupt sources mark the context, data-in and data-out phases, and each can be enabled separately. Three DMA request lines let a DMA engine follow the same three phases without polling. The cipher rounds and IV chaining are left to the core. The block only carries the mode, the single/triple selector and the direction to the core.

Top module: `cipher_ctx_regs`

## Requirements
- R1: After reset, the control word reads 0x8000_0000 (context flag in bit 31 set, mode/triple/direction 0, input ready bit 1 and output ready bit 0 both clear), the system status word reads 1, the interrupt status reads 0 and `irq` is low.
- R2: Word offsets are fixed: key3 low/high 0x00/0x04, key2 0x08/0x0C, key1 0x10/0x14, IV 0x18/0x1C, control 0x20, length 0x24, data low/high 0x28/0x2C, DMA enables 0x34, system status 0x38, interrupt status 0x3C, interrupt enable 0x40. Key and IV words read back what was written while the context flag was 1.
- R3: While the context flag is 0, writes to the key, IV and control registers have no effect.
- R4: A nonzero write to the length register while the context flag is 1 clears the flag and sets input ready. A zero write is ignored. The length register always reads 0.
- R5: A block goes to the core only when the data low word and then the data high word are written while input ready is 1. `core_start` then pulses for exactly one cycle, on the cycle after the high write, and input ready clears. A high write with no low write before it starts nothing.
- R6: When `core_done` is high while a block is in flight, the result appears at data low/high (low word = bits 31:0) and output ready sets. Reading the low word leaves output ready set. Reading the high word clears it.
- R7: Each finished block subtracts 8 from the remaining length, saturating at 0. When the high result word is read, input ready sets again if length remains. Otherwise the context flag returns to 1 and input ready stays 0.
- R8: Byte k of the block (byte 0 = bits 7:0 of the low word, byte 7 = bits 31:24 of the high word) is passed to the core as zero when the remaining length is k or less.
- R9: Interrupt status bit 0 (context) sets when a context finishes, bit 1 (data-in) when input ready sets, and bit 2 (data-out) when output ready sets. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some interrupt status bit and the same bit of the interrupt enable register (same layout) are both 1.
- R11: DMA enable bit 7 gates `dma_ctx_req` with the context flag, bit 6 gates `dma_out_req` with output ready, and bit 5 gates `dma_in_req` with input ready.
- R12: `core_mode`, `core_triple` and `core_encrypt` follow control bits 5:4, 3 and 2. The core key and IV outputs follow the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| core_start | output | 1 | One-cycle block launch |
| core_block | output | 64 | Padded input block |
| core_key1 | output | 64 | First key |
| core_key2 | output | 64 | Second key |
| core_key3 | output | 64 | Third key |
| core_iv | output | 64 | Initialization vector |
| core_mode | output | 2 | Chaining mode select |
| core_triple | output | 1 | Triple operation select |
| core_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| core_done | input | 1 | Result valid pulse |
| core_result | input | 64 | Processed block |
| irq | output | 1 | Interrupt request |
| dma_ctx_req | output | 1 | DMA request for next context |
| dma_in_req | output | 1 | DMA request for input data |
| dma_out_req | output | 1 | DMA request for output data |

## Verification
The bench goes after the final partial block. A design that pads by the wrong byte order, or from the length after the decrement, hands the core nonzero bytes past the end. It also checks the last high-word read. A design that gets that read wrong reopens input ready when it should return the context flag, or the reverse. A lone high-half write, a zero length write and key or control writes during a busy context must change nothing. A design that launches on the high write alone, or lets a busy context's key change, is caught by the start count and by readback. Interrupt clear-by-one is checked bit by bit, so a design that clears the whole status word on any write shows a wrong value.

// File: rtl/cipher_ctx_regs.sv
module cipher_ctx_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          core_start,
  output logic [63:0]   core_block,
  output logic [63:0]   core_key1,
  output logic [63:0]   core_key2,
  output logic [63:0]   core_key3,
  output logic [63:0]   core_iv,
  output logic [1:0]    core_mode,
  output logic          core_triple,
  output logic          core_encrypt,
  input  logic          core_done,
  input  logic [63:0]   core_result,
  output logic          irq,
  output logic          dma_ctx_req,
  output logic          dma_in_req,
  output logic          dma_out_req
);
  localparam int BW = 64;
  localparam int NBYTES = BW / 8;
  localparam logic [AW-1:0] A_K3L = AW'(8'h00), A_K3H = AW'(8'h04);
  localparam logic [AW-1:0] A_K2L = AW'(8'h08), A_K2H = AW'(8'h0C);
  localparam logic [AW-1:0] A_K1L = AW'(8'h10), A_K1H = AW'(8'h14);
  localparam logic [AW-1:0] A_IVL = AW'(8'h18), A_IVH = AW'(8'h1C);
  localparam logic [AW-1:0] A_CTL = AW'(8'h20), A_LEN = AW'(8'h24);
  localparam logic [AW-1:0] A_DL  = AW'(8'h28), A_DH  = AW'(8'h2C);
  localparam logic [AW-1:0] A_DMA = AW'(8'h34), A_SYS = AW'(8'h38);
  localparam logic [AW-1:0] A_IST = AW'(8'h3C), A_IEN = AW'(8'h40);

  logic [BW-1:0] key1, key2, key3, iv, din, dout, pad_mask;
  logic [1:0]    mode;
  logic          triple, enc;
  logic [31:0]   remaining;
  logic          ctx_open, in_rdy, out_rdy, lo_seen, busy, start_q;
  logic [2:0]    irq_st, irq_en, dma_en;

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;
  wire cfg_wr   = wr & ctx_open;
  wire len_go   = wr && bus_addr == A_LEN && ctx_open && bus_wdata != 32'd0;
  wire lo_wr    = wr && bus_addr == A_DL && in_rdy;
  wire hi_wr    = wr && bus_addr == A_DH && in_rdy;
  wire launch   = hi_wr & lo_seen;
  wire finish   = core_done & busy;
  wire hi_rd    = rd && bus_addr == A_DH && out_rdy;
  wire ctx_end  = hi_rd && remaining == 32'd0;
  wire in_again = hi_rd && remaining != 32'd0;
  wire [2:0] ev = {finish, len_go | in_again, ctx_end};
  wire [2:0] w1c = (wr && bus_addr == A_IST) ? bus_wdata[2:0] : 3'b000;

  for (genvar b = 0; b < NBYTES; b++) begin : g_pad
    assign pad_mask[8*b +: 8] = (remaining > 32'(b)) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key1 <= '0; key2 <= '0; key3 <= '0; iv <= '0;
      mode <= '0; triple <= 1'b0; enc <= 1'b0;
    end else if (cfg_wr) begin
      case (bus_addr)
        A_K3L: key3[31:0]  <= bus_wdata;
        A_K3H: key3[63:32] <= bus_wdata;
        A_K2L: key2[31:0]  <= bus_wdata;
        A_K2H: key2[63:32] <= bus_wdata;
        A_K1L: key1[31:0]  <= bus_wdata;
        A_K1H: key1[63:32] <= bus_wdata;
        A_IVL: iv[31:0]    <= bus_wdata;
        A_IVH: iv[63:32]   <= bus_wdata;
        A_CTL: begin
          mode   <= bus_wdata[5:4];
          triple <= bus_wdata[3];
          enc    <= bus_wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_open  <= 1'b1;
      in_rdy    <= 1'b0;
      out_rdy   <= 1'b0;
      lo_seen   <= 1'b0;
      busy      <= 1'b0;
      start_q   <= 1'b0;
      remaining <= '0;
      din       <= '0;
      dout      <= '0;
    end else begin
      start_q <= launch;
      if (len_go) begin
        remaining <= bus_wdata;
        ctx_open  <= 1'b0;
        in_rdy    <= 1'b1;
        lo_seen   <= 1'b0;
      end
      if (lo_wr) begin
        din[31:0] <= bus_wdata;
        lo_seen   <= 1'b1;
      end
      if (hi_wr) din[63:32] <= bus_wdata;
      if (launch) begin
        in_rdy  <= 1'b0;
        lo_seen <= 1'b0;
        busy    <= 1'b1;
      end
      if (finish) begin
        dout      <= core_result;
        out_rdy   <= 1'b1;
        busy      <= 1'b0;
        remaining <= (remaining > 32'd8) ? remaining - 32'd8 : 32'd0;
      end
      if (hi_rd) out_rdy <= 1'b0;
      if (ctx_end) ctx_open <= 1'b1;
      if (in_again) in_rdy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_st <= '0;
      irq_en <= '0;
      dma_en <= '0;
    end else begin
      irq_st <= (irq_st & ~w1c) | ev;
      if (wr && bus_addr == A_IEN) irq_en <= bus_wdata[2:0];
      if (wr && bus_addr == A_DMA) dma_en <= bus_wdata[7:5];
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      A_K3L: bus_rdata = key3[31:0];
      A_K3H: bus_rdata = key3[63:32];
      A_K2L: bus_rdata = key2[31:0];
      A_K2H: bus_rdata = key2[63:32];
      A_K1L: bus_rdata = key1[31:0];
      A_K1H: bus_rdata = key1[63:32];
      A_IVL: bus_rdata = iv[31:0];
      A_IVH: bus_rdata = iv[63:32];
      A_CTL: bus_rdata = {ctx_open, 25'd0, mode, triple, enc, in_rdy, out_rdy};
      A_DL:  bus_rdata = dout[31:0];
      A_DH:  bus_rdata = dout[63:32];
      A_DMA: bus_rdata = {24'd0, dma_en, 5'd0};
      A_SYS: bus_rdata = 32'd1;
      A_IST: bus_rdata = {29'd0, irq_st};
      A_IEN: bus_rdata = {29'd0, irq_en};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign core_start   = start_q;
  assign core_block   = din & pad_mask;
  assign core_key1    = key1;
  assign core_key2    = key2;
  assign core_key3    = key3;
  assign core_iv      = iv;
  assign core_mode    = mode;
  assign core_triple  = triple;
  assign core_encrypt = enc;
  assign irq          = |(irq_st & irq_en);
  assign dma_ctx_req  = dma_en[2] & ctx_open;
  assign dma_out_req  = dma_en[1] & out_rdy;
  assign dma_in_req   = dma_en[0] & in_rdy;
endmodule

// File: rtl/cipher_ctx_chk.sv
module cipher_ctx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic        core_start,
  input logic        ctx_open,
  input logic        in_rdy,
  input logic        out_rdy,
  input logic [63:0] key1,
  input logic [31:0] remaining,
  input logic [2:0]  irq_st,
  input logic        dma_in_req
);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !ctx_open && !in_rdy);
  // R6
  rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rdy && out_rdy));
  // R3
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_open |=> $stable(key1));
  // R7
  rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_open |=> remaining <= $past(remaining));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 8'h3C) |=> (irq_st & $past(irq_st)) == $past(irq_st));
  // R11
  dma_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_in_req |-> in_rdy);
endmodule

bind cipher_ctx_regs cipher_ctx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(8'(bus_addr)), .core_start(core_start), .ctx_open(ctx_open),
  .in_rdy(in_rdy), .out_rdy(out_rdy), .key1(key1), .remaining(remaining),
  .irq_st(irq_st), .dma_in_req(dma_in_req)
);

// File: tb/tb_cipher_ctx_regs.sv
module tb_cipher_ctx_regs;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        core_start, core_triple, core_encrypt, irq;
  logic [63:0] core_block, core_key1, core_key2, core_key3, core_iv;
  logic [1:0]  core_mode;
  logic        core_done = 1'b0;
  logic [63:0] core_result = '0;
  logic        dma_ctx_req, dma_in_req, dma_out_req;
  int n_chk = 0, n_err = 0, cyc = 0, st_cnt = 0, dly = 0;
  logic [63:0] cap_blk = '0;

  always #2 clk = ~clk;

  cipher_ctx_regs dut (.*);

  function automatic logic [63:0] model(input logic [63:0] b, k1, k3, input logic tr, en);
    logic [63:0] x = b ^ k1 ^ (tr ? k3 : 64'd0);
    return en ? x : ~x;
  endfunction

  function automatic logic [63:0] pad(input logic [63:0] b, input int rem);
    logic [63:0] r = b;
    for (int k = 0; k < 8; k++) if (rem <= k) r[8*k +: 8] = 8'h00;
    return r;
  endfunction

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      cap_blk <= core_block;
      st_cnt  <= st_cnt + 1;
      dly     <= 1 + int'($urandom % 4);
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        core_done   <= 1'b1;
        core_result <= model(cap_blk, core_key1, core_key3, core_triple, core_encrypt);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_out(input string req);
    logic [31:0] c;
    for (int i = 0; i < 40; i++) begin
      rd(8'h20, c);
      if (c[0]) return;
    end
    chk(req, 0, 1);
  endtask

  task automatic wr64(input logic [7:0] a, input logic [63:0] v);
    wr(a, v[31:0]); wr(a + 8'h4, v[63:32]);
  endtask

  task automatic run_ctx(input int len, input logic [1:0] md, input logic tr, en, input logic [63:0] k1, k3);
    logic [31:0] c, lo, hi;
    logic [63:0] blk, exp;
    int rem = len;
    wr64(8'h10, k1); wr64(8'h00, k3);
    wr(8'h20, {26'd0, md, tr, en, 2'b00});
    wr(8'h24, len);
    rd(8'h20, c);
    chk("R4 ctl after start", c, {1'b0, 25'd0, md, tr, en, 2'b10});
    chk("R12 core mode/triple/dir", {core_mode, core_triple, core_encrypt}, {md, tr, en});
    while (rem > 0) begin
      blk = {$urandom, $urandom};
      wr(8'h28, blk[31:0]); wr(8'h2C, blk[63:32]);
      wait_out("R6 output ready");
      chk("R8 padded block", cap_blk, pad(blk, rem));
      exp = model(pad(blk, rem), k1, k3, tr, en);
      rd(8'h28, lo); rd(8'h2C, hi);
      chk("R6 result", {hi, lo}, exp);
      rem = (rem > 8) ? rem - 8 : 0;
      rd(8'h20, c);
      chk("R7 flags after read", {c[31], c[1:0]}, (rem == 0) ? 3'b100 : 3'b010);
    end
  endtask

  initial begin
    logic [31:0] v;
    int s0;
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h20, v); chk("R1 ctl reset", v, 32'h8000_0000);
    rd(8'h38, v); chk("R1 sys status", v, 1);
    rd(8'h3C, v); chk("R1 irq status", v, 0);
    chk("R1 irq low", irq, 0);

    wr64(8'h08, 64'h1122_3344_5566_7788); wr64(8'h18, 64'hA5A5_0F0F_C3C3_9696);
    rd(8'h0C, v); chk("R2 key2 high", v, 32'h1122_3344);
    rd(8'h18, v); chk("R2 iv low", v, 32'hC3C3_9696);
    chk("R12 core iv", core_iv, 64'hA5A5_0F0F_C3C3_9696);
    chk("R12 core key2", core_key2, 64'h1122_3344_5566_7788);

    wr(8'h24, 0);
    rd(8'h20, v); chk("R4 zero length ignored", v, 32'h8000_0000);

    wr(8'h34, 32'hE0);
    #1 chk("R11 dma idle", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b100);
    wr64(8'h10, 64'h0F0F_0F0F_F0F0_F0F0);
    wr(8'h20, 32'h4); wr(8'h24, 12);
    rd(8'h24, v); chk("R4 length reads zero", v, 0);
    #1 chk("R11 dma in", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b010);
    wr(8'h10, 32'hDEAD_BEEF); wr(8'h20, 32'h3C);
    rd(8'h10, v); chk("R3 key ignored", v, 32'hF0F0_F0F0);
    rd(8'h20, v); chk("R3 ctl ignored", v, 32'h0000_0006);
    s0 = st_cnt;
    wr(8'h2C, 32'h1234_5678);
    repeat (4) @(negedge clk);
    chk("R5 high alone no start", st_cnt, s0);
    wr(8'h28, 32'h0BAD_F00D); wr(8'h2C, 32'h1357_9BDF);
    repeat (8) @(negedge clk);
    chk("R5 single start", st_cnt, s0 + 1);
    #1 chk("R11 dma out", {dma_ctx_req, dma_in_req, dma_out_req}, 3'b001);
    rd(8'h28, v); chk("R6 low result", v, 32'h0BAD_F00D ^ 32'hF0F0_F0F0);
    rd(8'h20, v); chk("R6 low read keeps ready", v[1:0], 2'b01);
    rd(8'h2C, v); chk("R6 high result", v, 32'h1357_9BDF ^ 32'h0F0F_0F0F);
    rd(8'h20, v); chk("R7 more data", {v[31], v[1:0]}, 3'b010);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    wait_out("R6 output ready 2");
    chk("R8 four byte tail", cap_blk, 64'h0000_0000_FFFF_FFFF);
    rd(8'h2C, v);
    rd(8'h20, v); chk("R7 context reopened", {v[31], v[1:0]}, 3'b100);

    rd(8'h3C, v); chk("R9 all status set", v, 7);
    chk("R10 irq masked", irq, 0);
    wr(8'h40, 32'h4); #1 chk("R10 irq enabled", irq, 1);
    wr(8'h3C, 32'h2);
    rd(8'h3C, v); chk("R9 w1c one bit", v, 5);
    wr(8'h3C, 32'h4); #1 chk("R10 irq cleared", irq, 0);
    rd(8'h3C, v); chk("R9 bit0 kept", v, 1);

    for (int n = 0; n < 8; n++) begin
      run_ctx(int'($urandom_range(48, 1)), 2'($urandom % 3), 1'($urandom), 1'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom});
    end
    run_ctx(1, 2'd1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    run_ctx(16, 2'd2, 1'b0, 1'b1, 64'h5555_AAAA_5555_AAAA, 64'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule